// File: doc/BRIEF.md
# Accumulator ALU with Packed Condition Flags

This block is the arithmetic and logic datapath of an 8-bit accumulator machine. Each operation takes the accumulator, a second byte operand, an optional pair of 16-bit register-pair operands and the current flag byte. It produces a result and a new flag byte. Byte operations are add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR, negate, one's complement, set carry and complement carry. Pair operations are a 16-bit add, a 16-bit add with carry and a 16-bit subtract with borrow.

The surrounding core decodes instructions, fetches operands and presents them together with a one-cycle strobe. The block latches the result and the flag byte on that edge and holds them until the next strobe. The flag byte is packed with a fixed bit layout, because branch and condition logic elsewhere reads individual bits of it.

Top module: `accflag_alu`

## Requirements
- R1: While the active-low reset is asserted, `result_o` and `flags_o` read zero.
- R2: Outputs change only on a clock edge where `strobe_i` is high. Opcode 15 leaves both outputs unchanged even when strobed. On an edge without the strobe, the inputs have no effect.
- R3: The flag byte is packed as sign bit 7, zero bit 6, half-carry bit 4, parity/overflow bit 2, subtract bit 1 and carry bit 0. Bits 5 and 3 copy result bits 5 and 3 for byte operations, and result bits 13 and 11 for pair operations. Byte results sit in bits 7:0 of `result_o`, and bits 15:8 are zero.
- R4: Add (opcode 0) and add with carry (opcode 1, carry-in = flag bit 0) set C from the bit-7 carry-out, H from the bit-3 carry-out, P/V from signed overflow, S and Z from the result, and clear N.
- R5: Subtract (opcode 2) and subtract with borrow (opcode 3) compute A − B − borrow. C is the borrow out of bit 7, H is the borrow out of bit 3, P/V is signed overflow, S and Z follow the result, and N = 1.
- R6: Compare (opcode 4) sets the flags exactly as subtract does, but S, Z and bits 5/3 take the difference, and the result output equals the accumulator.
- R7: AND (5), OR (6) and XOR (7) set S and Z from the result, set P/V when the result has an even number of ones, and clear N and C. H is 1 for AND and 0 for OR and XOR.
- R8: Negate (opcode 8) yields 0 − A with N = 1. C is set when A was nonzero, P/V is set only when A was 80h, and H is set when the low nibble of A was nonzero.
- R9: Complement (opcode 9) yields the bitwise inverse of A and sets H and N. Set carry (10) sets C and clears H and N. Complement carry (11) moves the old C into H, inverts C and clears N. All three keep S, Z and P/V, and 10 and 11 pass A to the result.
- R10: Pair add (opcode 12) yields P + Q. H is the carry out of bit 11, C is the carry out of bit 15, and N is cleared. S, Z and P/V keep their incoming values.
- R11: Pair add with carry (13) and pair subtract with borrow (14) use flag bit 0 as carry or borrow in. S comes from bit 15 and Z from the 16-bit result, and P/V is signed 16-bit overflow. H is the carry or borrow at bit 11/12 and C is the carry or borrow at bit 15. N is 0 for 13 and 1 for 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Latch the operation result on this edge |
| op_i | input | 4 | Operation select (codes in R4–R11, 15 = no update) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second byte operand |
| pair_a_i | input | 16 | First register-pair operand |
| pair_b_i | input | 16 | Second register-pair operand |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 16 | Latched result |
| flags_o | output | 8 | Latched flag byte |

## Verification
The properties assume that `op_i`, the operands and `flags_i` are known, and held steady through any cycle in which `strobe_i` is high. They also assume the flag byte arrives already packed as R3 describes. The bench changes every input only at the falling edge, through its driver task. It never leaves an input undriven after reset. Its idle cycles deliberately change operands while the strobe is low, so that the hold property is exercised with moving inputs.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_NEG  = 4'd8,
        OP_CPL  = 4'd9,
        OP_SCF  = 4'd10,
        OP_CCF  = 4'd11,
        OP_ADDW = 4'd12,
        OP_ADCW = 4'd13,
        OP_SBCW = 4'd14,
        OP_NONE = 4'd15
    } alu_op_e;

    localparam int FL_C  = 0;
    localparam int FL_N  = 1;
    localparam int FL_PV = 2;
    localparam int FL_H  = 4;
    localparam int FL_Z  = 6;
    localparam int FL_S  = 7;

    // field order matches the packed flag byte, sign at bit 7
    typedef struct packed {
        logic s;
        logic z;
        logic x5;
        logic h;
        logic x3;
        logic pv;
        logic n;
        logic c;
    } flags_t;

endpackage

// File: rtl/accalu_byte_unit.sv
module accalu_byte_unit
    import accalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [7:0]          fin_i,
    output logic [DATA_W-1:0]   res_o,
    output logic [7:0]          fout_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    flags_t              fin;
    flags_t              fo;
    logic                is_sub;
    logic                cin;
    logic                upd_sz;
    logic [DATA_W-1:0]   opa;
    logic [DATA_W-1:0]   opb;
    logic [DATA_W:0]     full;
    logic [HALF_W:0]     nib;
    logic                ovf;
    logic [DATA_W-1:0]   res;
    logic [DATA_W-1:0]   sz_src;
    logic                unused_xbits;

    assign unused_xbits = ^{fin.x5, fin.x3};

    // shared adder/subtractor; negate is 0 - A on the same path
    always_comb begin
        fin    = flags_t'(fin_i);
        is_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_NEG);
        cin    = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;
        opa    = (op == OP_NEG) ? '0  : a_i;
        opb    = (op == OP_NEG) ? a_i : b_i;
        if (is_sub) begin
            full = {1'b0, opa} - {1'b0, opb} - {{DATA_W{1'b0}}, cin};
            nib  = {1'b0, opa[HALF_W-1:0]} - {1'b0, opb[HALF_W-1:0]}
                   - {{HALF_W{1'b0}}, cin};
            ovf  = (opa[MSB] != opb[MSB]) && (full[MSB] != opa[MSB]);
        end else begin
            full = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
            nib  = {1'b0, opa[HALF_W-1:0]} + {1'b0, opb[HALF_W-1:0]}
                   + {{HALF_W{1'b0}}, cin};
            ovf  = (opa[MSB] == opb[MSB]) && (full[MSB] != opa[MSB]);
        end
    end

    // per-operation result and flag rules
    always_comb begin
        res    = a_i;
        fo     = fin;
        upd_sz = 1'b0;
        sz_src = res;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP: begin
                res    = (op == OP_CMP) ? a_i : full[DATA_W-1:0];
                fo.h   = nib[HALF_W];
                fo.pv  = ovf;
                fo.n   = is_sub;
                fo.c   = full[DATA_W];
                upd_sz = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                if (op == OP_AND)     res = a_i & b_i;
                else if (op == OP_OR) res = a_i | b_i;
                else                  res = a_i ^ b_i;
                fo.h   = (op == OP_AND);
                fo.pv  = ~^res;
                fo.n   = 1'b0;
                fo.c   = 1'b0;
                upd_sz = 1'b1;
            end
            OP_CPL: begin
                res  = ~a_i;
                fo.h = 1'b1;
                fo.n = 1'b1;
            end
            OP_SCF: begin
                fo.c = 1'b1;
                fo.h = 1'b0;
                fo.n = 1'b0;
            end
            OP_CCF: begin
                fo.h = fin.c;
                fo.c = ~fin.c;
                fo.n = 1'b0;
            end
            default: begin
                res = a_i;
            end
        endcase
        sz_src = (op == OP_CMP) ? full[DATA_W-1:0] : res;
        if (upd_sz) begin
            fo.s = sz_src[MSB];
            fo.z = (sz_src == '0);
        end
        fo.x5 = sz_src[5];
        fo.x3 = sz_src[3];
    end

    assign res_o  = res;
    assign fout_o = fo;

endmodule

// File: rtl/accalu_pair_unit.sv
module accalu_pair_unit
    import accalu_pkg::*;
#(
    parameter int WIDE_W = 16
) (
    input  alu_op_e             op,
    input  logic [WIDE_W-1:0]   p_i,
    input  logic [WIDE_W-1:0]   q_i,
    input  logic [7:0]          fin_i,
    output logic [WIDE_W-1:0]   res_o,
    output logic [7:0]          fout_o
);
    localparam int LOW_W  = WIDE_W - 4;
    localparam int MSB    = WIDE_W - 1;
    localparam int X5_POS = WIDE_W / 2 + 5;
    localparam int X3_POS = WIDE_W / 2 + 3;

    flags_t              fin;
    flags_t              fo;
    logic                cin;
    logic                is_sub;
    logic [WIDE_W:0]     full;
    logic [LOW_W:0]      low;
    logic                ovf;
    logic [WIDE_W-1:0]   res;
    logic                unused_xbits;

    assign unused_xbits = ^{fin.x5, fin.x3};

    always_comb begin
        fin    = flags_t'(fin_i);
        is_sub = (op == OP_SBCW);
        cin    = ((op == OP_ADCW) || (op == OP_SBCW)) ? fin.c : 1'b0;
        if (is_sub) begin
            full = {1'b0, p_i} - {1'b0, q_i} - {{WIDE_W{1'b0}}, cin};
            low  = {1'b0, p_i[LOW_W-1:0]} - {1'b0, q_i[LOW_W-1:0]}
                   - {{LOW_W{1'b0}}, cin};
            ovf  = (p_i[MSB] != q_i[MSB]) && (full[MSB] != p_i[MSB]);
        end else begin
            full = {1'b0, p_i} + {1'b0, q_i} + {{WIDE_W{1'b0}}, cin};
            low  = {1'b0, p_i[LOW_W-1:0]} + {1'b0, q_i[LOW_W-1:0]}
                   + {{LOW_W{1'b0}}, cin};
            ovf  = (p_i[MSB] == q_i[MSB]) && (full[MSB] != p_i[MSB]);
        end
    end

    always_comb begin
        res = p_i;
        fo  = fin;
        case (op)
            OP_ADDW: begin
                res  = full[WIDE_W-1:0];
                fo.h = low[LOW_W];
                fo.c = full[WIDE_W];
                fo.n = 1'b0;
            end
            OP_ADCW, OP_SBCW: begin
                res   = full[WIDE_W-1:0];
                fo.s  = full[MSB];
                fo.z  = (full[WIDE_W-1:0] == '0);
                fo.h  = low[LOW_W];
                fo.pv = ovf;
                fo.n  = is_sub;
                fo.c  = full[WIDE_W];
            end
            default: begin
                res = p_i;
            end
        endcase
        fo.x5 = res[X5_POS];
        fo.x3 = res[X3_POS];
    end

    assign res_o  = res;
    assign fout_o = fo;

endmodule

// File: rtl/accflag_alu.sv
module accflag_alu
    import accalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe_i,
    input  logic [3:0]            op_i,
    input  logic [DATA_W-1:0]     acc_i,
    input  logic [DATA_W-1:0]     opnd_i,
    input  logic [2*DATA_W-1:0]   pair_a_i,
    input  logic [2*DATA_W-1:0]   pair_b_i,
    input  logic [7:0]            flags_i,
    output logic [2*DATA_W-1:0]   result_o,
    output logic [7:0]            flags_o
);
    localparam int WIDE_W = 2 * DATA_W;

    typedef struct packed {
        logic [WIDE_W-1:0] result;
        logic [7:0]        flags;
    } state_t;

    alu_op_e             op_sel;
    logic [DATA_W-1:0]   byte_res;
    logic [7:0]          byte_fl;
    logic [WIDE_W-1:0]   pair_res;
    logic [7:0]          pair_fl;
    state_t              state_d;
    state_t              state_q;

    assign op_sel = alu_op_e'(op_i);

    accalu_byte_unit #(.DATA_W(DATA_W)) u_byte (
        .op     (op_sel),
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .fin_i  (flags_i),
        .res_o  (byte_res),
        .fout_o (byte_fl)
    );

    accalu_pair_unit #(.WIDE_W(WIDE_W)) u_pair (
        .op     (op_sel),
        .p_i    (pair_a_i),
        .q_i    (pair_b_i),
        .fin_i  (flags_i),
        .res_o  (pair_res),
        .fout_o (pair_fl)
    );

    always_comb begin
        state_d = state_q;
        if (strobe_i) begin
            case (op_sel)
                OP_ADDW, OP_ADCW, OP_SBCW: begin
                    state_d.result = pair_res;
                    state_d.flags  = pair_fl;
                end
                OP_NONE: begin
                    state_d = state_q;
                end
                default: begin
                    state_d.result = {{DATA_W{1'b0}}, byte_res};
                    state_d.flags  = byte_fl;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign flags_o  = state_q.flags;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(result_o) && $stable(flags_o))); // R2
    AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && op_sel == OP_NONE) |=> ($stable(result_o) && $stable(flags_o))); // R2
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && op_sel == OP_CMP) |=> (result_o == {{DATA_W{1'b0}}, $past(acc_i)})); // R6
    AST_SUB_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && (op_sel inside {OP_SUB, OP_SBC, OP_CMP, OP_NEG, OP_SBCW}))
        |=> flags_o[FL_N]); // R5
    AST_LOGIC_CLEARS_NC: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && (op_sel inside {OP_AND, OP_OR, OP_XOR}))
        |=> (!flags_o[FL_N] && !flags_o[FL_C])); // R7
    AST_NEG_ZERO_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && op_sel == OP_NEG && acc_i == '0)
        |=> (!flags_o[FL_C] && flags_o[FL_Z])); // R8
    AST_SCF_SETS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && op_sel == OP_SCF) |=> (flags_o[FL_C] && !flags_o[FL_H])); // R9
    AST_PAIR_ADD_KEEPS_SZV: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && op_sel == OP_ADDW)
        |=> (flags_o[FL_S] == $past(flags_i[FL_S]) && flags_o[FL_Z] == $past(flags_i[FL_Z])
             && flags_o[FL_PV] == $past(flags_i[FL_PV]))); // R10

endmodule

// File: tb/accflag_alu_bench.sv
module accflag_alu_bench;

    typedef struct packed {
        logic [15:0] res;
        logic [7:0]  fl;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [7:0]  acc_i = 8'd0;
    logic [7:0]  opnd_i = 8'd0;
    logic [15:0] pair_a_i = 16'd0;
    logic [15:0] pair_b_i = 16'd0;
    logic [7:0]  flags_i = 8'd0;
    logic [15:0] result_o;
    logic [7:0]  flags_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic  pend = 1'b0;
    exp_t  sb_q[$];
    string tag_q[$];
    exp_t  last_exp = '0;
    logic [31:0] rng = 32'h1BADF00D;

    always #4 clk = ~clk;

    accflag_alu u_accflag_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .pair_a_i (pair_a_i),
        .pair_b_i (pair_b_i),
        .flags_i  (flags_i),
        .result_o (result_o),
        .flags_o  (flags_o)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:        return "R4";
            4'd2, 4'd3:        return "R5";
            4'd4:              return "R6";
            4'd5, 4'd6, 4'd7:  return "R7";
            4'd8:              return "R8";
            4'd9, 4'd10, 4'd11: return "R9";
            4'd12:             return "R10";
            4'd13, 4'd14:      return "R11";
            default:           return "R2";
        endcase
    endfunction

    // reference model written from the requirement text, integer arithmetic
    function automatic exp_t model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                   input logic [15:0] p, input logic [15:0] q, input logic [7:0] f);
        exp_t e;
        int ai, bi, pi, qi, ci, sa, sb, sp, sq, t, ts;
        logic s_f, z_f, h_f, v_f, n_f, c_f, x5, x3;
        logic [15:0] r;
        ai = int'(a); bi = int'(b); pi = int'(p); qi = int'(q);
        sa = (ai > 127) ? ai - 256 : ai;
        sb = (bi > 127) ? bi - 256 : bi;
        sp = (pi > 32767) ? pi - 65536 : pi;
        sq = (qi > 32767) ? qi - 65536 : qi;
        s_f = f[7]; z_f = f[6]; h_f = f[4]; v_f = f[2]; n_f = f[1]; c_f = f[0];
        r  = 16'(ai);
        ci = (op == 4'd1 || op == 4'd3 || op == 4'd13 || op == 4'd14) ? int'(f[0]) : 0;
        case (op)
            4'd0, 4'd1: begin
                t = ai + bi + ci; r = 16'(t & 255);
                c_f = (t > 255); h_f = ((ai & 15) + (bi & 15) + ci) > 15;
                ts = sa + sb + ci; v_f = (ts > 127) || (ts < -128); n_f = 1'b0;
                s_f = r[7]; z_f = (r == 16'd0);
            end
            4'd2, 4'd3, 4'd4: begin
                t = ai - bi - ci; r = 16'(t & 255);
                c_f = (t < 0); h_f = ((ai & 15) - (bi & 15) - ci) < 0;
                ts = sa - sb - ci; v_f = (ts > 127) || (ts < -128); n_f = 1'b1;
                s_f = r[7]; z_f = (r == 16'd0);
            end
            4'd8: begin
                t = 0 - ai; r = 16'(t & 255);
                c_f = (ai != 0); v_f = (ai == 128); h_f = ((ai & 15) != 0); n_f = 1'b1;
                s_f = r[7]; z_f = (r == 16'd0);
            end
            4'd5, 4'd6, 4'd7: begin
                if (op == 4'd5)      r = 16'(ai & bi);
                else if (op == 4'd6) r = 16'(ai | bi);
                else                 r = 16'(ai ^ bi);
                h_f = (op == 4'd5); n_f = 1'b0; c_f = 1'b0;
                v_f = ($countones(r[7:0]) % 2) == 0;
                s_f = r[7]; z_f = (r == 16'd0);
            end
            4'd9: begin
                r = 16'((~ai) & 255); h_f = 1'b1; n_f = 1'b1;
            end
            4'd10: begin
                c_f = 1'b1; h_f = 1'b0; n_f = 1'b0;
            end
            4'd11: begin
                h_f = f[0]; c_f = !f[0]; n_f = 1'b0;
            end
            4'd12: begin
                t = pi + qi; r = 16'(t & 65535);
                h_f = ((pi & 4095) + (qi & 4095)) > 4095; c_f = (t > 65535); n_f = 1'b0;
            end
            4'd13: begin
                t = pi + qi + ci; r = 16'(t & 65535);
                h_f = ((pi & 4095) + (qi & 4095) + ci) > 4095; c_f = (t > 65535); n_f = 1'b0;
                ts = sp + sq + ci; v_f = (ts > 32767) || (ts < -32768);
                s_f = r[15]; z_f = (r == 16'd0);
            end
            4'd14: begin
                t = pi - qi - ci; r = 16'(t & 65535);
                h_f = ((pi & 4095) - (qi & 4095) - ci) < 0; c_f = (t < 0); n_f = 1'b1;
                ts = sp - sq - ci; v_f = (ts > 32767) || (ts < -32768);
                s_f = r[15]; z_f = (r == 16'd0);
            end
            default: ;
        endcase
        if (op >= 4'd12) begin x5 = r[13]; x3 = r[11]; end
        else             begin x5 = r[5];  x3 = r[3];  end
        if (op == 4'd4) r = 16'(ai);
        e.res = r;
        e.fl  = {s_f, z_f, x5, h_f, x3, v_f, n_f, c_f};
        return e;
    endfunction

    task automatic check(input string tag, input exp_t exp);
        checks++;
        if (result_o !== exp.res || flags_o !== exp.fl) begin
            errors++;
            $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
                     tag, result_o, flags_o, exp.res, exp.fl);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] p, input logic [15:0] q, input logic [7:0] f,
                         input string tag);
        exp_t e;
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; pair_a_i = p; pair_b_i = q; flags_i = f;
        strobe_i = 1'b1;
        if (op == 4'd15) e = last_exp;
        else             e = model(op, a, b, p, q, f);
        sb_q.push_back(e);
        tag_q.push_back((tag == "") ? tag_of(op) : tag);
        last_exp = e;
    endtask

    // strobe low while operands move: outputs must hold (R2)
    task automatic idle_check();
        @(negedge clk);
        strobe_i = 1'b0;
        op_i = 4'd0; acc_i = 8'hA5; opnd_i = 8'h3C; pair_a_i = 16'hBEEF; flags_i = 8'hFF;
        @(negedge clk);
        check("R2", last_exp);
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // scoreboard monitor
    always @(posedge clk) pend <= strobe_i && rst_n;

    always @(negedge clk) begin
        if (pend) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: result=%h flags=%h expected no update", result_o, flags_o);
            end else begin
                check(tag_q.pop_front(), sb_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t zero_e;
        zero_e = '0;
        repeat (3) @(negedge clk);
        check("R1", zero_e);
        rst_n = 1'b1;

        // R3: undefined flag bits follow result bits
        drive(4'd0,  8'h20, 8'h08, 16'h0, 16'h0, 8'h00, "R3");
        drive(4'd12, 8'h00, 8'h00, 16'h2000, 16'h0800, 8'h00, "R3");
        // R4 add corners
        drive(4'd0, 8'h0F, 8'h01, 16'h0, 16'h0, 8'h00, "");
        drive(4'd0, 8'h7F, 8'h01, 16'h0, 16'h0, 8'h00, "");
        drive(4'd0, 8'hFF, 8'h01, 16'h0, 16'h0, 8'h00, "");
        drive(4'd1, 8'h10, 8'h20, 16'h0, 16'h0, 8'h01, "");
        drive(4'd1, 8'hFF, 8'h00, 16'h0, 16'h0, 8'h01, "");
        // R5 subtract corners
        drive(4'd2, 8'h10, 8'h01, 16'h0, 16'h0, 8'h00, "");
        drive(4'd2, 8'h80, 8'h01, 16'h0, 16'h0, 8'h00, "");
        drive(4'd2, 8'h00, 8'h01, 16'h0, 16'h0, 8'h00, "");
        drive(4'd3, 8'h05, 8'h05, 16'h0, 16'h0, 8'h01, "");
        drive(4'd3, 8'h05, 8'h04, 16'h0, 16'h0, 8'h01, "");
        // R6 compare
        drive(4'd4, 8'h42, 8'h42, 16'h0, 16'h0, 8'h00, "");
        drive(4'd4, 8'h10, 8'h20, 16'h0, 16'h0, 8'h00, "");
        // R7 logic with parity
        drive(4'd5, 8'hF0, 8'h3C, 16'h0, 16'h0, 8'hFF, "");
        drive(4'd6, 8'h01, 8'h02, 16'h0, 16'h0, 8'h13, "");
        drive(4'd7, 8'hFF, 8'hFE, 16'h0, 16'h0, 8'h00, "");
        drive(4'd7, 8'h55, 8'h55, 16'h0, 16'h0, 8'h01, "");
        // R8 negate
        drive(4'd8, 8'h00, 8'h00, 16'h0, 16'h0, 8'h00, "");
        drive(4'd8, 8'h80, 8'h00, 16'h0, 16'h0, 8'h00, "");
        drive(4'd8, 8'h01, 8'h00, 16'h0, 16'h0, 8'h00, "");
        drive(4'd8, 8'h10, 8'h00, 16'h0, 16'h0, 8'h00, "");
        // R9 complement and carry control
        drive(4'd9,  8'h5A, 8'h00, 16'h0, 16'h0, 8'h00, "");
        drive(4'd9,  8'h5A, 8'h00, 16'h0, 16'h0, 8'hC5, "");
        drive(4'd10, 8'h33, 8'h00, 16'h0, 16'h0, 8'h00, "");
        drive(4'd10, 8'h33, 8'h00, 16'h0, 16'h0, 8'hD2, "");
        drive(4'd11, 8'h44, 8'h00, 16'h0, 16'h0, 8'h01, "");
        drive(4'd11, 8'h44, 8'h00, 16'h0, 16'h0, 8'hC4, "");
        // R10 pair add keeps S, Z, P/V
        drive(4'd12, 8'h00, 8'h00, 16'h0FFF, 16'h0001, 8'hC4, "");
        drive(4'd12, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 8'h00, "");
        drive(4'd12, 8'h00, 8'h00, 16'h1234, 16'h1111, 8'h44, "");
        // R11 pair carry/borrow forms
        drive(4'd13, 8'h00, 8'h00, 16'h7FFF, 16'h0000, 8'h01, "");
        drive(4'd13, 8'h00, 8'h00, 16'hFFFF, 16'h0000, 8'h01, "");
        drive(4'd14, 8'h00, 8'h00, 16'h1000, 16'h0000, 8'h01, "");
        drive(4'd14, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h01, "");
        drive(4'd14, 8'h00, 8'h00, 16'h8000, 16'h0001, 8'h00, "");
        // R2: reserved code holds, then idle hold
        drive(4'd15, 8'hEE, 8'hEE, 16'hEEEE, 16'hEEEE, 8'hEE, "");
        idle_check();

        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r1, r2;
            rng = next_rng(rng); r1 = rng;
            rng = next_rng(rng); r2 = rng;
            drive(r1[3:0], r1[11:4], r1[19:12], r2[15:0], r2[31:16], r1[27:20], "");
            if (r1[31:29] == 3'd0) idle_check();
        end
        idle_check();

        // R1: reset in mid-run clears both outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", zero_e);
        rst_n = 1'b1;
        last_exp = '0;
        idle_check();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule